// File: doc/BRIEF.md
# Sign-Controlled SIMD Accumulate Unit

This block is an arithmetic extension for a processor datapath that forms `D + b*C` over a packed word. The operand word `C` and the accumulator word `D` are each split into narrow signed integer lanes. The bit vector `b` holds one hard decision per lane, and each bit is read as +1 or -1. No lane contains a multiplier. Each bit only chooses whether its lane adds `C` to `D` or subtracts it. The unit is meant to speed up correlation and detection loops, where soft integer samples meet hard bits.

The caller presents both words and the sign vector together with a one-cycle issue strobe. One clock later the packed result appears on a registered output, and a valid flag is high for exactly that cycle. The result then stays put until the next issue. Each lane wraps within its own width, and no carry crosses a lane boundary. Lane width, lane count and the adder structure are parameters. The defaults give eight 8-bit lanes in a 64-bit word, with an 8-bit sign vector.

Top module: `sign_steer_accum`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, `result_o` becomes all zeros and `valid_o` becomes 0.
- R2: `valid_o` is 1 in the cycle right after a clock edge where `issue_i` was 1 and `rst` was 0. In every other cycle it is 0.
- R3: Lane i occupies bits `[i*LANE_W +: LANE_W]` of each word, with lane 0 in bits 7:0 by default. It is steered by `sign_b_i[i]`. A sign bit of 1 means +1, and that lane of the result is `D + C`.
- R4: A sign bit of 0 means -1, and that lane of the result is `D - C`.
- R5: Each lane wraps modulo 2^LANE_W and drops its carry or borrow. Lane results never affect one another. For example, 0x7F + 0x01 gives 0x80, 0x00 - 0x01 gives 0xFF, and 0xFF + 0xFF gives 0xFE in every lane.
- R6: In cycles with no issue, `result_o` keeps its last value whatever happens on `opnd_c_i`, `acc_d_i` and `sign_b_i`.
- R7: Issues on consecutive cycles each yield their own result, one per cycle, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue strobe; operands are taken on this edge |
| opnd_c_i | input | LANES*LANE_W | Packed integer operand C |
| acc_d_i | input | LANES*LANE_W | Packed accumulator D |
| sign_b_i | input | LANES | Per-lane sign bits (1 = add, 0 = subtract) |
| result_o | output | LANES*LANE_W | Registered packed result |
| valid_o | output | 1 | High for the one cycle holding a fresh result |

## Verification
A wrong sign decode or a swapped lane mapping shows up in the very next cycle after an issue. It appears as a corrupted byte in `result_o` at the lane concerned, so the vectors use sign patterns that tell lanes apart, such as a single set bit or alternating bits. A carry leaking across a lane boundary shows up on the same cycle, as an off-by-one in the next lane up. The saturating all-ones and boundary operands are there to provoke it. A result register that loads without an issue, or a stale valid flag, shows up during idle stretches in which the inputs keep changing.

// File: rtl/sign_steer_accum_pkg.sv
package sign_steer_accum_pkg;

   // Default geometry of the packed word
   localparam int unsigned DEF_LANE_W = 8;
   localparam int unsigned DEF_LANES  = 8;

   // Adder structure inside each lane
   typedef enum int unsigned {
      LANE_ADD_MUX    = 0,  // separate sum and difference, selected by sign
      LANE_ADD_INVERT = 1   // one adder, operand inverted with carry-in for minus
   } lane_add_style_e;

   localparam int unsigned NUM_ADD_STYLES = 2;

endpackage

// File: rtl/sign_steer_lane.sv
module sign_steer_lane
   import sign_steer_accum_pkg::*;
#(
   parameter int unsigned W     = DEF_LANE_W,
   parameter int unsigned STYLE = LANE_ADD_MUX
) (
   input  logic [W-1:0] acc_i,
   input  logic [W-1:0] opnd_i,
   input  logic         plus_i,
   output logic [W-1:0] sum_o
);

   generate
      if (STYLE == LANE_ADD_MUX) begin : g_mux
         logic [W-1:0] add_res;
         logic [W-1:0] sub_res;
         always_comb begin
            add_res = acc_i + opnd_i;
            sub_res = acc_i - opnd_i;
            sum_o   = plus_i ? add_res : sub_res;
         end
      end else begin : g_invert
         logic [W-1:0] flip;
         logic [W-1:0] cin;
         always_comb begin
            flip  = opnd_i ^ {W{~plus_i}};
            cin   = {{(W-1){1'b0}}, ~plus_i};
            sum_o = acc_i + flip + cin;
         end
      end
   endgenerate

endmodule

// File: rtl/sign_steer_lane_array.sv
module sign_steer_lane_array
   import sign_steer_accum_pkg::*;
#(
   parameter int unsigned LANE_W = DEF_LANE_W,
   parameter int unsigned LANES  = DEF_LANES,
   parameter int unsigned STYLE  = LANE_ADD_MUX,
   localparam int unsigned WORD_W = LANE_W * LANES
) (
   input  logic [WORD_W-1:0] acc_i,
   input  logic [WORD_W-1:0] opnd_i,
   input  logic [LANES-1:0]  sign_i,
   output logic [WORD_W-1:0] sum_o
);

   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      sign_steer_lane #(
         .W     (LANE_W),
         .STYLE (STYLE)
      ) u_lane (
         .acc_i  (acc_i[gi*LANE_W +: LANE_W]),
         .opnd_i (opnd_i[gi*LANE_W +: LANE_W]),
         .plus_i (sign_i[gi]),
         .sum_o  (sum_o[gi*LANE_W +: LANE_W])
      );
   end

endmodule

// File: rtl/sign_steer_out_reg.sv
module sign_steer_out_reg #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] data_o,
   output logic             valid_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= load_i;
         if (load_i) begin
            data_o <= data_i;
         end
      end
   end

endmodule

// File: rtl/sign_steer_accum.sv
module sign_steer_accum
   import sign_steer_accum_pkg::*;
#(
   parameter int unsigned LANE_W    = DEF_LANE_W,
   parameter int unsigned LANES     = DEF_LANES,
   parameter int unsigned ADD_STYLE = LANE_ADD_MUX,
   localparam int unsigned WORD_W   = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              issue_i,
   input  logic [WORD_W-1:0] opnd_c_i,
   input  logic [WORD_W-1:0] acc_d_i,
   input  logic [LANES-1:0]  sign_b_i,
   output logic [WORD_W-1:0] result_o,
   output logic              valid_o
);

   // Elaboration-time parameter checks
   generate
      if (LANE_W < 2) begin : g_bad_lane_w
         $error("sign_steer_accum: LANE_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("sign_steer_accum: LANES must be at least 1");
      end
      if (ADD_STYLE >= NUM_ADD_STYLES) begin : g_bad_style
         $error("sign_steer_accum: ADD_STYLE out of range");
      end
   endgenerate

   logic [WORD_W-1:0] lane_sum;

   sign_steer_lane_array #(
      .LANE_W (LANE_W),
      .LANES  (LANES),
      .STYLE  (ADD_STYLE)
   ) u_lanes (
      .acc_i  (acc_d_i),
      .opnd_i (opnd_c_i),
      .sign_i (sign_b_i),
      .sum_o  (lane_sum)
   );

   sign_steer_out_reg #(
      .WIDTH (WORD_W)
   ) u_out (
      .clk     (clk),
      .rst     (rst),
      .load_i  (issue_i),
      .data_i  (lane_sum),
      .data_o  (result_o),
      .valid_o (valid_o)
   );

endmodule

// File: rtl/sign_steer_accum_chk.sv
module sign_steer_accum_chk #(
   parameter int unsigned LANE_W  = 8,
   parameter int unsigned LANES   = 8,
   localparam int unsigned WORD_W = LANE_W * LANES
) (
   input logic              clk,
   input logic              rst,
   input logic              issue_i,
   input logic [WORD_W-1:0] opnd_c_i,
   input logic [WORD_W-1:0] acc_d_i,
   input logic [LANES-1:0]  sign_b_i,
   input logic [WORD_W-1:0] result_o,
   input logic              valid_o
);

   // Operands captured at each accepted issue
   logic [WORD_W-1:0] cap_c;
   logic [WORD_W-1:0] cap_d;
   logic [LANES-1:0]  cap_b;

   always_ff @(posedge clk) begin
      if (issue_i) begin
         cap_c <= opnd_c_i;
         cap_d <= acc_d_i;
         cap_b <= sign_b_i;
      end
   end

   // R1: a reset edge leaves zero result and no valid
   assert_reset_clear_R1: assert property (@(posedge clk)
      $past(rst) |-> (result_o == '0 && !valid_o));

   // R2: valid follows an accepted issue by exactly one cycle
   assert_valid_timing_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (valid_o == $past(issue_i)));

   // R6: result is held when nothing was issued
   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(issue_i)) |-> $stable(result_o));

   // R3, R4, R5: each lane adds or subtracts per its own sign bit, wrapping alone
   for (genvar gi = 0; gi < LANES; gi++) begin : g_lane_chk
      logic [LANE_W-1:0] exp_lane;
      always_comb begin
         if (cap_b[gi]) exp_lane = cap_d[gi*LANE_W +: LANE_W] + cap_c[gi*LANE_W +: LANE_W];
         else           exp_lane = cap_d[gi*LANE_W +: LANE_W] - cap_c[gi*LANE_W +: LANE_W];
      end
      assert_lane_math_R3: assert property (@(posedge clk) disable iff (rst)
         valid_o |-> (result_o[gi*LANE_W +: LANE_W] == exp_lane));
   end

endmodule

bind sign_steer_accum sign_steer_accum_chk #(
   .LANE_W (LANE_W),
   .LANES  (LANES)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .issue_i  (issue_i),
   .opnd_c_i (opnd_c_i),
   .acc_d_i  (acc_d_i),
   .sign_b_i (sign_b_i),
   .result_o (result_o),
   .valid_o  (valid_o)
);

// File: tb/tb_sign_steer_accum.sv
`timescale 1ns/1ps
module tb_sign_steer_accum;

   localparam int LW = 8;
   localparam int NL = 8;
   localparam int WW = LW * NL;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          issue_i = 1'b0;
   logic [WW-1:0] opnd_c_i = '0;
   logic [WW-1:0] acc_d_i = '0;
   logic [NL-1:0] sign_b_i = '0;
   logic [WW-1:0] result_o;
   logic          valid_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [WW-1:0] val;
      string         tag;
   } exp_t;

   exp_t          sb_q[$];
   logic [WW-1:0] last_res = '0;
   bit            mon_on = 1'b0;

   always #5 clk = ~clk;

   sign_steer_accum dut (
      .clk      (clk),
      .rst      (rst),
      .issue_i  (issue_i),
      .opnd_c_i (opnd_c_i),
      .acc_d_i  (acc_d_i),
      .sign_b_i (sign_b_i),
      .result_o (result_o),
      .valid_o  (valid_o)
   );

   function automatic logic [WW-1:0] model(logic [WW-1:0] c, logic [WW-1:0] d, logic [NL-1:0] b);
      logic [WW-1:0] r;
      for (int i = 0; i < NL; i++) begin
         if (b[i]) r[i*LW +: LW] = d[i*LW +: LW] + c[i*LW +: LW];
         else      r[i*LW +: LW] = d[i*LW +: LW] - c[i*LW +: LW];
      end
      return r;
   endfunction

   task automatic check(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: one issue per call, expected value pushed to the scoreboard
   task automatic drive(logic [WW-1:0] c, logic [WW-1:0] d, logic [NL-1:0] b, string tag);
      exp_t e;
      opnd_c_i = c;
      acc_d_i  = d;
      sign_b_i = b;
      issue_i  = 1'b1;
      e.val    = model(c, d, b);
      e.tag    = tag;
      sb_q.push_back(e);
      @(negedge clk);
      issue_i  = 1'b0;
   endtask

   // Idle cycles with wandering inputs (R6)
   task automatic idle_noise(int n);
      for (int k = 0; k < n; k++) begin
         opnd_c_i = {$urandom, $urandom};
         acc_d_i  = {$urandom, $urandom};
         sign_b_i = NL'($urandom);
         @(negedge clk);
      end
   endtask

   // Monitor: one sample per cycle, just after the active edge
   always @(posedge clk) begin
      #1;
      if (mon_on) begin
         checks++;
         if (valid_o !== (sb_q.size() > 0)) begin
            errors++;
            $display("FAIL R2: valid actual=%b expected=%b", valid_o, sb_q.size() > 0);
         end
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, result_o, e.val);
            last_res = e.val;
         end else begin
            check("R6 hold", result_o, last_res);
         end
      end
   end

   initial begin
      logic [WW-1:0] lf;
      repeat (3) @(negedge clk);
      check("R1 reset result", result_o, '0);
      check("R1 reset valid", {63'd0, valid_o}, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      mon_on = 1'b1;

      // R3: all lanes add
      drive(64'h0102030405060708, 64'h1010101010101010, 8'hFF, "R3 all add");
      // R4: all lanes subtract
      drive(64'h0102030405060708, 64'h1010101010101010, 8'h00, "R4 all sub");
      // R3: only lane 0 adds, lane order
      drive(64'h0101010101010101, 64'h2020202020202020, 8'h01, "R3 lane0 only");
      // R3: only top lane adds
      drive(64'h0101010101010101, 64'h2020202020202020, 8'h80, "R3 lane7 only");
      // R5: overflow and underflow wrap per lane
      drive(64'h0101010101010101, 64'h7F007F007F007F00, 8'hAA, "R5 wrap alt");
      drive(64'h01FF01FF01FF01FF, 64'h00FF00FF00FF00FF, 8'h55, "R5 wrap mix");
      // R5: all ones, no carry across lanes
      drive('1, '1, 8'hFF, "R5 carry isolation");
      drive('1, '0, 8'h00, "R5 borrow isolation");
      idle_noise(4);

      // R7: back-to-back stream
      lf = 64'hACE1_2357_BEEF_0F0F;
      for (int n = 0; n < 40; n++) begin
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
         drive(lf, {lf[31:0], lf[63:32]}, lf[7:0] ^ lf[45:38], "R7 stream");
      end
      idle_noise(5);

      // R1: reset in mid-run clears state
      rst = 1'b1;
      mon_on = 1'b0;
      @(negedge clk);
      check("R1 mid reset result", result_o, '0);
      check("R1 mid reset valid", {63'd0, valid_o}, 64'd0);
      rst = 1'b0;
      last_res = '0;
      @(negedge clk);
      mon_on = 1'b1;
      idle_noise(2);
      drive(64'h8080808080808080, 64'h8080808080808080, 8'h0F, "R4 after reset");
      idle_noise(3);
      mon_on = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule